// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer. An 8-bit up-counter is driven by a programmable prescaler, and a control/status byte holds the enable bit, the overflow flag and the ratio select. Software reaches both registers through a simple write port and a read port. A write is accepted only when its top byte holds the key that belongs to the target register, so a stray store cannot reload or stop the timer.

While the timer is enabled, the prescaler divides the clock by 32 shifted left by the select code. Each time the prescaler completes a period, the counter advances by one. When the counter rolls over from 0xFF to 0x00, the block sets the overflow flag and raises `wdt_pulse` for one cycle. Software keeps the timer from expiring by reloading the counter with a keyed write. After an expiry it clears the flag with a keyed control write.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter is 0x00, the control/status byte is 0x00 (timer disabled, select 000, flag clear), and `wdt_pulse` is low.
- R2: A write with `wr_sel`=0 whose top byte (`wr_data[BUS_W-1:BUS_W-8]`) is 0x5A loads `wr_data[7:0]` into the counter at that clock edge.
- R3: A write with `wr_sel`=1 whose top byte is 0xA5 loads bit 7 (enable), bits 6:4 (spare, no effect) and bits 2:0 (ratio select) from `wr_data[7:0]`.
- R4: A write whose top byte is not the key of the selected register is ignored: neither the counter nor the control/status byte changes. This includes a control key sent to the counter and a counter key sent to the control register.
- R5: `rd_data` is 8 bits wide and carries no key byte. With `rd_sel`=0 it shows the counter. With `rd_sel`=1 it shows the control/status byte: bit 7 enable, bits 6:4 spare, bit 3 overflow flag, bits 2:0 select.
- R6: While enabled, the counter advances once every 32·2^sel clock cycles: select 000 gives /32, 001 gives /64, and so on up to 111, which gives /4096.
- R7: While the enable bit is clear, the prescaler and the counter hold their values.
- R8: When the counter rolls over from 0xFF to 0x00, the overflow flag is set and `wdt_pulse` is high for exactly one cycle, at the same edge.
- R9: A keyed control write with bit 3 = 0 clears the overflow flag. A keyed control write with bit 3 = 1 leaves the flag unchanged.
- R10: Every keyed control write restarts the prescaler from zero. The first increment after such a write therefore comes exactly 32·2^sel cycles after the write edge.
- R11: If a keyed counter write lands on the same edge as a prescaler period end, the written value wins. No increment and no overflow happen at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Write target: 0 counter, 1 control/status |
| wr_data | input | BUS_W | Key in the top byte, value in bits 7:0 |
| rd_sel | input | 1 | Read source: 0 counter, 1 control/status |
| rd_data | output | 8 | Selected register value |
| wdt_pulse | output | 1 | One-cycle expiry pulse |

## Verification
The checker watches every cycle for several conditions:
- The expiry pulse never lasts more than one cycle, and it always coincides with a zero counter and a set flag.
- The flag only rises together with a pulse.
- A disabled timer holds still.
- A wrongly keyed counter write leaves the counter alone.
- A keyed control write always zeroes the prescaler.

The exact period for each of the eight ratios, the phase restart after a control write, and the write-versus-tick collision can only be shown by the bench's timed scenarios. The flag clear and keep rules are also shown there. All of these results are checked against the behavioural model on every clock.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          BUS_W      = 16,
  parameter logic [7:0]  CNT_KEY    = 8'h5A,
  parameter logic [7:0]  CTL_KEY    = 8'hA5,
  parameter int          BASE_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             wdt_pulse
);
  localparam int SEL_W     = 3;
  localparam int SHIFT_MAX = (1 << SEL_W) - 1;
  localparam int PRE_W     = BASE_SHIFT + SHIFT_MAX;

  logic [7:0]       cnt_q, ctl_q;
  logic [PRE_W-1:0] pre_q, pre_last;
  logic             pulse_q;

  wire [7:0] key    = wr_data[BUS_W-1 -: 8];
  wire [7:0] low    = wr_data[7:0];
  wire       cnt_wr = wr_en & ~wr_sel & (key == CNT_KEY);
  wire       ctl_wr = wr_en &  wr_sel & (key == CTL_KEY);
  wire       en     = ctl_q[7];

  assign pre_last = {PRE_W{1'b1}} >> (SHIFT_MAX - int'(ctl_q[SEL_W-1:0]));

  wire tick = en & ~ctl_wr & (pre_q == pre_last);
  wire wrap = tick & ~cnt_wr & (cnt_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ctl_q   <= '0;
      pre_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (ctl_wr) begin
        ctl_q <= {low[7:4], low[3] & ctl_q[3], low[2:0]};
        pre_q <= '0;
      end else begin
        if (wrap) ctl_q[3] <= 1'b1;
        if (en)   pre_q <= tick ? '0 : pre_q + 1'b1;
      end
      if (cnt_wr)    cnt_q <= low;
      else if (tick) cnt_q <= cnt_q + 8'd1;
    end
  end

  assign rd_data   = rd_sel ? ctl_q : cnt_q;
  assign wdt_pulse = pulse_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int         BUS_W = 16,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CTL_KEY = 8'hA5,
  parameter int         PRE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [BUS_W-1:0] wr_data,
  input logic [7:0]       cnt_q,
  input logic [7:0]       ctl_q,
  input logic [PRE_W-1:0] pre_q,
  input logic             wdt_pulse
);
  wire [7:0] key = wr_data[BUS_W-1 -: 8];

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pulse |=> !wdt_pulse);
  p_pulse_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pulse |-> (cnt_q == 8'h00 && ctl_q[3]));
  p_pulse_prev_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pulse |-> $past(cnt_q) == 8'hFF);
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[3]) |-> wdt_pulse);
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[7] && !wr_en) |=> ($stable(cnt_q) && $stable(pre_q)));
  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && key != CNT_KEY && !ctl_q[7]) |=> $stable(cnt_q));
  p_phase_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && key == CTL_KEY) |=> pre_q == '0);
endmodule

bind keyed_wdt keyed_wdt_chk #(
  .BUS_W(BUS_W), .CNT_KEY(CNT_KEY), .CTL_KEY(CTL_KEY), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt_q(cnt_q), .ctl_q(ctl_q), .pre_q(pre_q), .wdt_pulse(wdt_pulse)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_data;
  logic        wdt_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_wdt u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .wdt_pulse(wdt_pulse));

  // behavioural reference model
  int m_cnt, m_pre, m_sel, m_en, m_ovf, m_sp, m_pulse;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_sel = 0; m_en = 0; m_ovf = 0; m_sp = 0; m_pulse = 0;
    end else begin
      bit cw, kw, tk;
      int lo;
      lo = wr_data[7:0];
      cw = wr_en && !wr_sel && wr_data[15:8] == 8'h5A;
      kw = wr_en &&  wr_sel && wr_data[15:8] == 8'hA5;
      tk = 0;
      m_pulse = 0;
      if (kw) begin
        m_en = (lo >> 7) & 1; m_sp = (lo >> 4) & 7; m_sel = lo & 7;
        if (((lo >> 3) & 1) == 0) m_ovf = 0;
        m_pre = 0;
      end else if (m_en != 0) begin
        if (m_pre == (32 << m_sel) - 1) begin m_pre = 0; tk = 1; end
        else m_pre++;
      end
      if (cw) m_cnt = lo;
      else if (tk) begin
        if (m_cnt == 255) begin m_cnt = 0; m_ovf = 1; m_pulse = 1; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int exp_rd;
    exp_rd = rd_sel ? ((m_en << 7) | (m_sp << 4) | (m_ovf << 3) | m_sel) : m_cnt;
    checks++;
    if (rd_data !== 8'(exp_rd) || wdt_pulse !== 1'(m_pulse)) begin
      errors++;
      $display("FAIL R2/R3/R6/R8/R11 model compare: act rd=%02h pulse=%0b exp rd=%02h pulse=%0d",
               rd_data, wdt_pulse, exp_rd, m_pulse);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] key, logic [7:0] val);
    wr_en = 1; wr_sel = sel; wr_data = {key, val};
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(bit sel, output int v);
    rd_sel = sel; #0.1; v = rd_data;
  endtask

  task automatic wait_cnt_change(int from, output int n);
    int v;
    n = 0;
    forever begin
      @(posedge clk); #1; n++;
      rd(0, v);
      if (v != from || n > 9000) break;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, v); chk("R1 counter", v, 0);
    rd(1, v); chk("R1 control", v, 0);
    chk("R1 pulse", wdt_pulse, 0);

    wr(0, 8'h12, 8'h77); rd(0, v); chk("R4 bad key counter", v, 0);
    wr(0, 8'hA5, 8'h77); rd(0, v); chk("R4 ctl key to counter", v, 0);
    wr(1, 8'h5A, 8'h85); rd(1, v); chk("R4 cnt key to control", v, 0);
    wr(0, 8'h5A, 8'h3C); rd(0, v); chk("R2 keyed counter load", v, 8'h3C);
    wr(1, 8'hA5, 8'h7A); rd(1, v); chk("R3 R5 control layout", v, 8'h72);
    wr(1, 8'hA5, 8'h00);
    repeat (200) @(posedge clk); #1;
    rd(0, v); chk("R7 disabled hold", v, 8'h3C);

    for (int k = 0; k < 8; k++) begin
      wr(0, 8'h5A, 8'h00);
      wr(1, 8'hA5, 8'h80 | 8'(k));
      wait_cnt_change(0, n);
      chk($sformatf("R6 period sel=%0d", k), n, 32 << k);
      rd(0, v); chk("R6 increment by one", v, 1);
      wr(1, 8'hA5, 8'h00);
    end

    wr(0, 8'h5A, 8'h00);
    wr(1, 8'hA5, 8'h82);
    repeat (50) @(posedge clk); #1;
    wr(1, 8'hA5, 8'h82);
    wait_cnt_change(0, n);
    chk("R10 phase restart", n, 128);

    wr(1, 8'hA5, 8'h00);
    wr(0, 8'h5A, 8'hFE);
    wr(1, 8'hA5, 8'h88);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!wdt_pulse && n < 500);
    chk("R8 pulse timing", n, 64);
    rd(0, v); chk("R8 counter wrapped", v, 0);
    rd(1, v); chk("R8 flag set", v, 8'h88);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", wdt_pulse, 0);

    wr(1, 8'hA5, 8'h08); rd(1, v); chk("R9 flag kept by 1", v, 8'h08);
    wr(1, 8'hA5, 8'h00); rd(1, v); chk("R9 flag cleared by 0", v, 8'h00);

    wr(0, 8'h5A, 8'hFF);
    wr(1, 8'hA5, 8'h80);
    repeat (31) @(posedge clk);
    #1 wr(0, 8'h5A, 8'h40);
    rd(0, v); chk("R11 write wins", v, 8'h40);
    chk("R11 no pulse", wdt_pulse, 0);
    rd(1, v); chk("R11 no flag", v, 8'h80);
    repeat (32) @(posedge clk); #1;
    rd(0, v); chk("R11 next tick", v, 8'h41);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule